// File: doc/BRIEF.md
# Banked Pattern Memory Mapper with RAM Overlay

This block sits between a host CPU, a video fetch engine and two pattern stores. The CPU programs eight 8-bit bank registers through a two-step protocol: a write to the select address picks a register (and a half-swap flag), and a write to the data address loads that register. The video engine then issues reads and writes on a 14-bit address. The block splits the 8 KB pattern space into 1 KB windows, turns the window into a raw bank number and routes the access.

Raw bank numbers 8 through 11 go to a private 4 KB RAM inside the block, so those four banks can be written and read back. Every other raw number goes to an external read-only pattern ROM, after being wrapped to the ROM bank count. Video writes that land on a ROM bank have no effect. On the CPU side the block also forms program-ROM addresses in 8 KB units. The upper program window is pinned to the last program bank.

Top module: `pattern_bank_mapper`

## Requirements
- R1: After reset every bank register is zero and the swap flag is clear. A read of 0x1000 then returns ROM bank 0, a read of 0x0400 returns ROM bank 1, and CPU address 0x8000 maps to program bank 0.
- R2: A CPU write with cpu_addr[15:13] = 3'b100 and cpu_addr[0] = 0 stores cpu_wdata[2:0] as the register index and cpu_wdata[7] as the swap flag. Bits 6:3 are ignored. A write in the same region with cpu_addr[0] = 1 loads cpu_wdata into the indexed register.
- R3: With swap clear, the 1 KB windows at video addresses 0x1000, 0x1400, 0x1800 and 0x1C00 take their raw bank from registers 2, 3, 4 and 5.
- R4: With swap clear, register 0 drives 0x0000 and register 1 drives 0x0800 as 2 KB windows. The lower 1 KB uses the value with bit 0 cleared and the upper 1 KB uses it with bit 0 set. vid_addr[9:0] is the offset inside the bank.
- R5: With the swap flag set, the 0x0000–0x0FFF and 0x1000–0x1FFF halves trade their window mappings.
- R6: A raw bank in 8..11 selects the internal RAM at byte (raw − 8)·1024 + offset. The four banks are independent, and a written byte reads back through any window that maps the same raw bank.
- R7: The RAM range test uses the raw register value. Raw banks 7 and 12 access ROM even when the RAM holds data at the same offset.
- R8: A raw bank outside 8..11 reads ROM bank (raw mod CHR_ROM_BANKS), presented on rom_addr as {bank, offset}. With 14 banks, 20 reads bank 6 and 255 reads bank 3.
- R9: A video write that maps to a ROM bank changes nothing. A later read returns the unchanged ROM byte, and RAM contents at the same offset are kept.
- R10: Read data appears on vid_rdata one cycle after vid_rd is sampled, with the same latency for RAM and ROM. In a cycle that follows a cycle without vid_rd, vid_rdata is 0.
- R11: Program address cpu_addr[14:13] = 0 uses register 6 and = 1 uses register 7, each taken mod PRG_BANKS. Window 2 is bank PRG_BANKS−2 and window 3 (0xE000) is always bank PRG_BANKS−1. prg_rom_addr = {bank, cpu_addr[12:0]}.
- R12: Video accesses with vid_addr[13] set are outside pattern space. They raise no rom_rd, write no RAM, and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| prg_rom_addr | output | 16 | Program ROM byte address |
| vid_addr | input | 14 | Video pattern address |
| vid_rd | input | 1 | Video read request |
| vid_wr | input | 1 | Video write request |
| vid_wdata | input | 8 | Video write data |
| vid_rdata | output | 8 | Video read data, one cycle after the request |
| rom_rd | output | 1 | Pattern ROM read strobe |
| rom_addr | output | 14 | Pattern ROM byte address |
| rom_rdata | input | 8 | Pattern ROM data, one cycle after rom_rd |

## Verification
A corrupted bank register, index or swap flag shows up on the first later read through the affected window. It gives the wrong ROM bank on rom_addr in the same cycle and the wrong byte on vid_rdata one cycle later. A fault in the RAM range test shows as a ROM byte where a written RAM byte is expected, or the reverse. A wrong RAM address shows as one bank's data appearing under another bank number on the next read-back. Program-window faults appear combinationally on prg_rom_addr as soon as the CPU address changes.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    localparam int BANK_W    = 8;
    localparam int NUM_REGS  = 8;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int OFS_W     = 10;
    localparam int VADDR_W   = 14;
    localparam int CPU_AW    = 16;
    localparam int PRG_OFS_W = 13;
    localparam int RAM_FIRST = 8;
    localparam int RAM_BANKS = 4;
    localparam int RAM_BW    = $clog2(RAM_BANKS);
    localparam int RAM_AW    = RAM_BW + OFS_W;
    localparam int RAM_DEPTH = RAM_BANKS << OFS_W;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [NUM_REGS-1:0][BANK_W-1:0] bank_arr_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             swap;
        bank_arr_t        bank;
    } bankfile_t;

    typedef struct packed {
        logic valid;
        logic from_ram;
    } rsel_t;
endpackage

// File: rtl/pbm_bank_regs.sv
module pbm_bank_regs
    import pbm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_wr,
    input  logic [2:0]           cpu_region,
    input  logic                 cpu_a0,
    input  logic [BANK_W-1:0]    cpu_wdata,
    output bank_arr_t            bank,
    output logic                 swap
);
    bankfile_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cpu_wr && cpu_region == 3'b100) begin
            if (!cpu_a0) begin
                st_d.idx  = cpu_wdata[IDX_W-1:0];
                st_d.swap = cpu_wdata[BANK_W-1];
            end else begin
                st_d.bank[st_q.idx] = cpu_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank = st_q.bank;
    assign swap = st_q.swap;
endmodule

// File: rtl/pbm_chr_decode.sv
module pbm_chr_decode
    import pbm_pkg::*;
#(
    parameter int CHR_ROM_BANKS = 14,
    localparam int CHR_BW = $clog2(CHR_ROM_BANKS),
    localparam int CHR_AW = CHR_BW + OFS_W
)(
    input  bank_arr_t             bank,
    input  logic                  swap,
    input  logic [VADDR_W-1:0]    vid_addr,
    input  logic                  vid_rd,
    input  logic                  vid_wr,
    output logic                  rom_rd,
    output logic [CHR_AW-1:0]     rom_addr,
    output logic                  ram_re,
    output logic                  ram_we,
    output logic [RAM_AW-1:0]     ram_addr
);
    logic [2:0]       win;
    bank_t            raw;
    logic             pattern;
    logic             in_ram;
    logic [OFS_W-1:0] ofs;

    always_comb begin
        ofs     = vid_addr[OFS_W-1:0];
        win     = vid_addr[12:10] ^ {swap, 2'b00};
        pattern = !vid_addr[13];
        case (win)
            3'd0:    raw = bank[0] & ~bank_t'(1);
            3'd1:    raw = bank[0] |  bank_t'(1);
            3'd2:    raw = bank[1] & ~bank_t'(1);
            3'd3:    raw = bank[1] |  bank_t'(1);
            default: raw = bank[win - 3'd2];
        endcase
        in_ram   = (raw >= bank_t'(RAM_FIRST)) &&
                   (raw <  bank_t'(RAM_FIRST + RAM_BANKS));
        ram_addr = {RAM_BW'(raw - bank_t'(RAM_FIRST)), ofs};
        rom_addr = {CHR_BW'(raw % bank_t'(CHR_ROM_BANKS)), ofs};
        ram_re   = pattern && in_ram && vid_rd;
        ram_we   = pattern && in_ram && vid_wr;
        rom_rd   = pattern && !in_ram && vid_rd;
    end
endmodule

// File: rtl/pbm_overlay_ram.sv
module pbm_overlay_ram
    import pbm_pkg::*;
(
    input  logic                 clk,
    input  logic                 re,
    input  logic                 we,
    input  logic [RAM_AW-1:0]    addr,
    input  logic [BANK_W-1:0]    wdata,
    output logic [BANK_W-1:0]    rdata
);
    logic [BANK_W-1:0] mem [RAM_DEPTH];
    logic [BANK_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/pbm_prg_map.sv
module pbm_prg_map
    import pbm_pkg::*;
#(
    parameter int PRG_BANKS = 6,
    localparam int PRG_BW = $clog2(PRG_BANKS),
    localparam int PRG_AW = PRG_BW + PRG_OFS_W
)(
    input  bank_t                   sel_lo,
    input  bank_t                   sel_hi,
    input  logic [PRG_OFS_W+1:0]    cpu_addr,
    output logic [PRG_AW-1:0]       prg_rom_addr
);
    logic [PRG_BW-1:0] pbank;

    always_comb begin
        case (cpu_addr[PRG_OFS_W+1:PRG_OFS_W])
            2'd0:    pbank = PRG_BW'(sel_lo % bank_t'(PRG_BANKS));
            2'd1:    pbank = PRG_BW'(sel_hi % bank_t'(PRG_BANKS));
            2'd2:    pbank = PRG_BW'(PRG_BANKS - 2);
            default: pbank = PRG_BW'(PRG_BANKS - 1);
        endcase
        prg_rom_addr = {pbank, cpu_addr[PRG_OFS_W-1:0]};
    end
endmodule

// File: rtl/pattern_bank_mapper.sv
module pattern_bank_mapper
    import pbm_pkg::*;
#(
    parameter int CHR_ROM_BANKS = 14,
    parameter int PRG_BANKS     = 6,
    localparam int CHR_AW = $clog2(CHR_ROM_BANKS) + OFS_W,
    localparam int PRG_AW = $clog2(PRG_BANKS) + PRG_OFS_W
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_wr,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [BANK_W-1:0]    cpu_wdata,
    output logic [PRG_AW-1:0]    prg_rom_addr,
    input  logic [VADDR_W-1:0]   vid_addr,
    input  logic                 vid_rd,
    input  logic                 vid_wr,
    input  logic [BANK_W-1:0]    vid_wdata,
    output logic [BANK_W-1:0]    vid_rdata,
    output logic                 rom_rd,
    output logic [CHR_AW-1:0]    rom_addr,
    input  logic [BANK_W-1:0]    rom_rdata
);
    bank_arr_t         bank;
    logic              swap;
    logic              ram_re, ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [BANK_W-1:0] ram_rdata;
    rsel_t             rs_d, rs_q;

    pbm_bank_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr     (cpu_wr),
        .cpu_region (cpu_addr[CPU_AW-1:CPU_AW-3]),
        .cpu_a0     (cpu_addr[0]),
        .cpu_wdata  (cpu_wdata),
        .bank       (bank),
        .swap       (swap)
    );

    pbm_chr_decode #(.CHR_ROM_BANKS(CHR_ROM_BANKS)) u_dec (
        .bank     (bank),
        .swap     (swap),
        .vid_addr (vid_addr),
        .vid_rd   (vid_rd),
        .vid_wr   (vid_wr),
        .rom_rd   (rom_rd),
        .rom_addr (rom_addr),
        .ram_re   (ram_re),
        .ram_we   (ram_we),
        .ram_addr (ram_addr)
    );

    pbm_overlay_ram u_ram (
        .clk   (clk),
        .re    (ram_re),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (vid_wdata),
        .rdata (ram_rdata)
    );

    pbm_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .sel_lo       (bank[6]),
        .sel_hi       (bank[7]),
        .cpu_addr     (cpu_addr[PRG_OFS_W+1:0]),
        .prg_rom_addr (prg_rom_addr)
    );

    // read-return stage: remembers which source answers next cycle
    always_comb begin
        rs_d.valid    = vid_rd && !vid_addr[VADDR_W-1];
        rs_d.from_ram = ram_re;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign vid_rdata = !rs_q.valid   ? '0 :
                       rs_q.from_ram ? ram_rdata : rom_rdata;
endmodule

// File: rtl/pbm_checks.sv
module pbm_checks #(
    parameter int CHR_ROM_BANKS = 14,
    parameter int PRG_BANKS     = 6,
    localparam int CHR_AW = $clog2(CHR_ROM_BANKS) + 10,
    localparam int PRG_BW = $clog2(PRG_BANKS),
    localparam int PRG_AW = PRG_BW + 13
)(
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [PRG_AW-1:0] prg_rom_addr,
    input logic [13:0]       vid_addr,
    input logic              vid_rd,
    input logic              vid_wr,
    input logic [7:0]        vid_rdata,
    input logic              rom_rd,
    input logic [CHR_AW-1:0] rom_addr
);
    a_r12_no_rom_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_rd && vid_addr[13]) |-> !rom_rd);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_rd |=> vid_rdata == 8'h00);

    a_r8_rom_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> int'(rom_addr[CHR_AW-1:10]) < CHR_ROM_BANKS);

    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> rom_addr[9:0] == vid_addr[9:0]);

    a_r9_no_rom_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_wr && !vid_rd) |-> !rom_rd);

    a_r11_last_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15:13] == 3'b111 |->
            prg_rom_addr[PRG_AW-1:13] == PRG_BW'(PRG_BANKS - 1));
endmodule

bind pattern_bank_mapper pbm_checks #(
    .CHR_ROM_BANKS (CHR_ROM_BANKS),
    .PRG_BANKS     (PRG_BANKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .prg_rom_addr (prg_rom_addr),
    .vid_addr     (vid_addr),
    .vid_rd       (vid_rd),
    .vid_wr       (vid_wr),
    .vid_rdata    (vid_rdata),
    .rom_rd       (rom_rd),
    .rom_addr     (rom_addr)
);

// File: tb/pattern_bank_mapper_tb_top.sv
module pattern_bank_mapper_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cpu_wr = 0;
    logic [15:0] cpu_addr = 0;
    logic [7:0]  cpu_wdata = 0;
    logic [15:0] prg_rom_addr;
    logic [13:0] vid_addr = 0;
    logic        vid_rd = 0, vid_wr = 0;
    logic [7:0]  vid_wdata = 0;
    logic [7:0]  vid_rdata;
    logic        rom_rd;
    logic [13:0] rom_addr;
    logic [7:0]  rom_rdata = 0;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // pattern ROM model: byte = {bank[3:0], offset[3:0]}, one-cycle latency
    always @(posedge clk) if (rom_rd) rom_rdata <= {rom_addr[13:10], rom_addr[3:0]};

    pattern_bank_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .prg_rom_addr(prg_rom_addr), .vid_addr(vid_addr),
        .vid_rd(vid_rd), .vid_wr(vid_wr), .vid_wdata(vid_wdata),
        .vid_rdata(vid_rdata), .rom_rd(rom_rd), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata)
    );

    function automatic logic [7:0] rom_byte(int bank, int ofs);
        return 8'(((bank % 14) << 4) | (ofs & 15));
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic cpu_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); cpu_wr = 0;
    endtask

    task automatic set_reg(int idx, logic [7:0] v, bit sw = 0);
        cpu_write(16'h8000, 8'(idx) | (sw ? 8'h80 : 8'h00));
        cpu_write(16'h8001, v);
    endtask

    task automatic vid_read(logic [13:0] a, output logic [7:0] d);
        @(negedge clk); vid_rd = 1; vid_addr = a;
        @(negedge clk); d = vid_rdata; vid_rd = 0;
    endtask

    task automatic vid_write(logic [13:0] a, logic [7:0] d);
        @(negedge clk); vid_wr = 1; vid_addr = a; vid_wdata = d;
        @(negedge clk); vid_wr = 0;
    endtask

    // {reg index, reg value, video address, expected byte}
    localparam logic [39:0] VEC [10] = '{
        {8'd2, 8'd5,   16'h1003, 8'h53},   // R3
        {8'd3, 8'd13,  16'h1401, 8'hD1},   // R3
        {8'd4, 8'd20,  16'h1802, 8'h62},   // R8 wrap 20 -> 6
        {8'd5, 8'd7,   16'h1C0F, 8'h7F},   // R3
        {8'd2, 8'd12,  16'h1005, 8'hC5},   // R8 12 stays 12
        {8'd0, 8'd6,   16'h0004, 8'h64},   // R4 low half
        {8'd0, 8'd6,   16'h0404, 8'h74},   // R4 high half
        {8'd1, 8'd3,   16'h0809, 8'h29},   // R4 bit 0 cleared
        {8'd1, 8'd3,   16'h0C09, 8'h39},   // R4 bit 0 set
        {8'd5, 8'd255, 16'h1C00, 8'h30}    // R8 wrap 255 -> 3
    };

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        cpu_addr = 16'h8000; #1;
        check("R1 prg", prg_rom_addr, 16'h0000);
        vid_read(14'h1000, d); check("R1 win4", d, rom_byte(0, 0));
        vid_read(14'h0400, d); check("R1 win1", d, rom_byte(1, 0));
        @(negedge clk); check("R10 idle zero", vid_rdata, 8'h00);

        foreach (VEC[i]) begin
            set_reg(int'(VEC[i][39:32]), VEC[i][31:24]);
            vid_read(VEC[i][21:8], d);
            check($sformatf("R3/R4/R8 vec%0d", i), d, VEC[i][7:0]);
        end

        // R2: index bits only, ignored bits 6:3, data through mirror address
        cpu_write(16'h8000, 8'h7A);
        cpu_write(16'h9FFF, 8'd4);
        vid_read(14'h1000, d); check("R2 index", d, rom_byte(4, 0));

        // R6: four independent RAM banks
        set_reg(2, 8); set_reg(3, 9); set_reg(4, 10); set_reg(5, 11);
        vid_write(14'h1000, 8'h08); vid_write(14'h1400, 8'h09);
        vid_write(14'h1800, 8'h0A); vid_write(14'h1C00, 8'h0B);
        vid_read(14'h1000, d); check("R6 bank8", d, 8'h08);
        vid_read(14'h1400, d); check("R6 bank9", d, 8'h09);
        vid_read(14'h1800, d); check("R6 bank10", d, 8'h0A);
        vid_read(14'h1C00, d); check("R6 bank11", d, 8'h0B);
        set_reg(2, 11);
        vid_read(14'h1000, d); check("R6 alias bank11", d, 8'h0B);
        @(negedge clk); check("R10 idle after RAM", vid_rdata, 8'h00);

        // R7: 7 and 12 are ROM
        set_reg(2, 8); vid_write(14'h1010, 8'hEE);
        set_reg(2, 7);  vid_read(14'h1010, d); check("R7 bank7", d, rom_byte(7, 16));
        set_reg(2, 12); vid_read(14'h1010, d); check("R7 bank12", d, rom_byte(12, 16));

        // R9: write to ROM bank ignored, RAM kept
        set_reg(2, 8);  vid_write(14'h1020, 8'h55);
        set_reg(2, 12); vid_write(14'h1020, 8'hFF);
        vid_read(14'h1020, d); check("R9 rom unchanged", d, rom_byte(12, 0));
        set_reg(2, 8);  vid_read(14'h1020, d); check("R9 ram kept", d, 8'h55);

        // R5: swap halves
        set_reg(2, 5, 1); set_reg(0, 6, 1);
        vid_read(14'h0003, d); check("R5 low->reg2", d, rom_byte(5, 3));
        vid_read(14'h1004, d); check("R5 high->reg0", d, rom_byte(6, 4));
        vid_read(14'h1404, d); check("R5 high+1", d, rom_byte(7, 4));
        cpu_write(16'h8000, 8'h00);

        // R11: program windows
        set_reg(6, 3); set_reg(7, 9);
        foreach (VEC[i]) ; // no-op keeps loop style consistent
        begin
            logic [15:0] pa [4] = '{16'h8123, 16'hA001, 16'hC002, 16'hE456};
            int          pb [4] = '{3, 3, 4, 5};
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); cpu_addr = pa[k]; #1;
                check($sformatf("R11 win%0d", k), prg_rom_addr,
                      16'((pb[k] << 13) | (pa[k] & 16'h1FFF)));
            end
        end

        // R12: outside pattern space
        set_reg(0, 8);
        vid_read(14'h0000, d); check("R12 pre", d, 8'h08);
        @(negedge clk); vid_rd = 1; vid_addr = 14'h2000; #1;
        check("R12 no rom_rd", {31'b0, rom_rd}, 0);
        @(negedge clk); d = vid_rdata; vid_rd = 0;
        check("R12 read zero", d, 8'h00);
        vid_write(14'h2000, 8'h77);
        vid_read(14'h0000, d); check("R12 ram kept", d, 8'h08);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog R10 got=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule